// File: doc/BRIEF.md
# Ten-Bit Serial Link Framing Datapath

This block is the digital core of a ten-bit serializer/deserializer for links that carry 8B/10B characters. On the transmit side, ten-bit characters are written into a short elastic buffer. Once every ten cycles of the bit clock, the serializer takes the next character from the buffer and shifts it onto a single serial output, one bit per cycle. When the buffer is empty, the serializer sends the previous character again. A one-cycle flag reports a write that found the buffer full, and another reports a load that found it empty.

On the receive side, serial bits are collected into a ten-bit window. When comma alignment is enabled and a comma appears in the first seven bit positions of the window, the window is presented at once as an aligned word and the word counter restarts. When alignment is disabled, words keep their current boundary. Each presented word has a one-cycle valid pulse and a flag that is high when the word holds a comma. A wrap control feeds the transmit serial stream into the receiver in place of the external serial input, so the link can be tested off-line.

All logic runs on one bit-rate clock. Clock recovery and line drivers are not part of this block.

Top module: `serdes10_datapath`

## Requirements
- R1: The serializer loads a new character on the first clock edge after reset and then on every tenth edge after that, so the character rate is exactly one tenth of the bit rate.
- R2: After a load, `ser_out` carries character bit 0 for one cycle, then bits 1 through 9 in rising order, one bit per cycle.
- R3: The transmit buffer holds 4 characters. A write when the buffer is not full is accepted. A write to a full buffer in a cycle with no load is dropped, is never transmitted, and raises `tx_ovf` for the one cycle after that write.
- R4: A load that finds the buffer empty sends the previously loaded character again (all zeros after reset) and raises `tx_unf` for the one cycle after the load.
- R5: The first bit received in a word appears on `rx_data[0]` and the tenth on `rx_data[9]`. If no realignment happens, a word is presented every ten cycles with `rx_valid` high for one cycle, and the first word after reset is made of the bits sampled on edges 1 to 10.
- R6: A presented word is a comma when `rx_data[6:0]` equals 7'b1111100 or 7'b0000011, which is the bit sequence 0011111 or 1100000 in arrival order. `rx_comma` is high with `rx_valid` for exactly such words, whatever the state of `comma_en`.
- R7: When `comma_en` is 1 and the last ten received bits hold a comma in positions 0 to 6, those ten bits are presented on that edge as a word with `rx_comma` high, and the next word ends ten bits later.
- R8: When `comma_en` is 0, a comma that does not fall on the current word boundary does not move the boundary. Words continue every ten bits from the old boundary.
- R9: When `loopback` is 1, the receiver takes its bits from the transmit serial stream and ignores `ser_in`.
- R10: Synchronous active-high reset empties the buffer, restarts both bit counters, and holds `ser_out`, `rx_valid`, `rx_comma`, `tx_ovf` and `tx_unf` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_wr | input | 1 | Write strobe for a transmit character |
| tx_data | input | 10 | Transmit character; bit 0 is sent first |
| tx_ovf | output | 1 | One-cycle pulse after a dropped write |
| tx_unf | output | 1 | One-cycle pulse after a load from an empty buffer |
| ser_out | output | 1 | Transmit serial stream |
| ser_in | input | 1 | External receive serial stream |
| loopback | input | 1 | 1: receiver takes its bits from `ser_out` |
| comma_en | input | 1 | 1: allow the receiver to realign on a comma |
| rx_data | output | 10 | Received word; bit 0 arrived first |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| rx_comma | output | 1 | Presented word holds a comma |

## Verification
The bench first starts a comma three bits away from the current boundary. With alignment enabled, the comma word must appear on the very edge its last bit arrives. A design that waited for the old boundary, or that realigned even with `comma_en` low, would present shifted words. The bench also fills the buffer and writes once more. A design that stored or wrapped the extra character would send it later on the wire. It then drains the buffer, and a design that sent stale or undefined data on underflow, instead of repeating the last character, would present a different word sequence. Running the whole transmit path through the wrap, while `ser_in` is held at 1, catches a wrong bit order or a receiver that still listens to the external pin.

// File: rtl/serdes10_pkg.sv
package serdes10_pkg;

   localparam int SD_CHAR_W   = 10;
   localparam int SD_COMMA_W  = 7;
   localparam int SD_FIFO_DEP = 4;

   // Comma value as read in rx_data[6:0] (arrival order 0011111)
   localparam logic [SD_COMMA_W-1:0] SD_COMMA_PAT = 7'b1111100;

   typedef enum logic {
      MATCH_POS_ONLY = 1'b0,
      MATCH_EITHER   = 1'b1
   } comma_match_e;

endpackage

// File: rtl/tx_char_fifo.sv
module tx_char_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         wr_drop
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] TOP_IDX = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_N  = CW'(DEPTH);

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          full, push, pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_N);
   assign pop     = rd_en && !empty;
   assign push    = wr_en && (!full || pop);
   assign wr_drop = wr_en && !push;
   assign rd_data = store[rp];

   always_ff @(posedge clk) begin
      if (push) store[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (wp == TOP_IDX) ? '0 : wp + 1'b1;
         if (pop)  rp <= (rp == TOP_IDX) ? '0 : rp + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   // R3
   depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= FULL_N);

   // R3
   drop_keeps_fill_chk: assert property (@(posedge clk) disable iff (rst)
      wr_drop |=> $stable(cnt));

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         fifo_empty,
   input  logic [W-1:0] fifo_data,
   output logic         fifo_rd,
   output logic         underrun,
   output logic         ser_out
);

   localparam int CNTW = $clog2(W);
   localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

   logic [CNTW-1:0] bit_cnt;
   logic [W-1:0]    sh, last_char, next_char;
   logic            load;

   assign load      = (bit_cnt == LAST);
   assign fifo_rd   = load;
   assign underrun  = load && fifo_empty;
   assign next_char = fifo_empty ? last_char : fifo_data;
   assign ser_out   = sh[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt   <= LAST;
         sh        <= '0;
         last_char <= '0;
      end else if (load) begin
         bit_cnt   <= '0;
         sh        <= next_char;
         last_char <= next_char;
      end else begin
         bit_cnt   <= bit_cnt + 1'b1;
         sh        <= {1'b0, sh[W-1:1]};
      end
   end

   // R2
   first_bit_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> (ser_out == $past(next_char[0])));

   // R4
   repeat_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (load && fifo_empty) |=> (sh == $past(last_char)));

endmodule

// File: rtl/rx_comma_aligner.sv
module rx_comma_aligner
   import serdes10_pkg::*;
#(
   parameter int                    W       = 10,
   parameter int                    COMMA_W = 7,
   parameter logic [COMMA_W-1:0]    PAT     = 7'b1111100,
   parameter comma_match_e          MATCH   = MATCH_EITHER
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bit_in,
   input  logic         align_en,
   output logic [W-1:0] word,
   output logic         word_valid,
   output logic         word_comma
);

   localparam int CNTW = $clog2(W);
   localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

   logic [W-1:0]    sh, win;
   logic [CNTW-1:0] cnt;
   logic            hit, emit;

   assign win = {bit_in, sh[W-1:1]};

   generate
      if (MATCH == MATCH_EITHER) begin : g_either
         assign hit = (win[COMMA_W-1:0] == PAT) || (win[COMMA_W-1:0] == ~PAT);
      end else begin : g_pos
         assign hit = (win[COMMA_W-1:0] == PAT);
      end
   endgenerate

   assign emit = (cnt == LAST) || (align_en && hit);

   always_ff @(posedge clk) begin
      if (rst) begin
         sh         <= '0;
         cnt        <= '0;
         word       <= '0;
         word_valid <= 1'b0;
         word_comma <= 1'b0;
      end else begin
         sh <= win;
         if (emit) begin
            cnt        <= '0;
            word       <= win;
            word_valid <= 1'b1;
            word_comma <= hit;
         end else begin
            cnt        <= cnt + 1'b1;
            word_valid <= 1'b0;
            word_comma <= 1'b0;
         end
      end
   end

   // R7
   realign_emit_chk: assert property (@(posedge clk) disable iff (rst)
      (align_en && hit) |=> (word_valid && word_comma));

   // R8
   hold_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      (!align_en && cnt != LAST) |=> !word_valid);

   // R6
   flag_with_word_chk: assert property (@(posedge clk) disable iff (rst)
      word_comma |-> word_valid);

endmodule

// File: rtl/serdes10_datapath.sv
module serdes10_datapath
   import serdes10_pkg::*;
#(
   parameter int                 CHAR_W     = SD_CHAR_W,
   parameter int                 FIFO_DEPTH = SD_FIFO_DEP,
   parameter int                 COMMA_W    = SD_COMMA_W,
   parameter logic [COMMA_W-1:0] COMMA_PAT  = SD_COMMA_PAT,
   parameter comma_match_e       MATCH      = MATCH_EITHER
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tx_wr,
   input  logic [CHAR_W-1:0] tx_data,
   output logic              tx_ovf,
   output logic              tx_unf,
   output logic              ser_out,
   input  logic              ser_in,
   input  logic              loopback,
   input  logic              comma_en,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_comma
);

   generate
      if (CHAR_W <= COMMA_W) begin : g_bad_comma
         $error("comma width must be smaller than the character width");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("transmit buffer needs at least two entries");
      end
   endgenerate

   logic [CHAR_W-1:0] f_data;
   logic              f_empty, f_rd, f_drop, under, rx_bit;

   tx_char_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (tx_wr),
      .wr_data (tx_data),
      .rd_en   (f_rd),
      .rd_data (f_data),
      .empty   (f_empty),
      .wr_drop (f_drop)
   );

   tx_serializer #(.W(CHAR_W)) i_ser (
      .clk        (clk),
      .rst        (rst),
      .fifo_empty (f_empty),
      .fifo_data  (f_data),
      .fifo_rd    (f_rd),
      .underrun   (under),
      .ser_out    (ser_out)
   );

   assign rx_bit = loopback ? ser_out : ser_in;

   rx_comma_aligner #(.W(CHAR_W), .COMMA_W(COMMA_W), .PAT(COMMA_PAT), .MATCH(MATCH)) i_rx (
      .clk        (clk),
      .rst        (rst),
      .bit_in     (rx_bit),
      .align_en   (comma_en),
      .word       (rx_data),
      .word_valid (rx_valid),
      .word_comma (rx_comma)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_ovf <= 1'b0;
         tx_unf <= 1'b0;
      end else begin
         tx_ovf <= f_drop;
         tx_unf <= under;
      end
   end

   // R3
   ovf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      tx_ovf |-> $past(tx_wr));

   // R4
   unf_single_chk: assert property (@(posedge clk) disable iff (rst)
      tx_unf |=> !tx_unf);

endmodule

// File: tb/test_serdes10_datapath.sv
`timescale 1ns/1ps
module test_serdes10_datapath;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tx_wr = 1'b0;
   logic [9:0] tx_data = '0;
   logic       ser_in = 1'b0;
   logic       loopback = 1'b0;
   logic       comma_en = 1'b0;
   logic       tx_ovf, tx_unf, ser_out, rx_valid, rx_comma;
   logic [9:0] rx_data;

   always #4 clk = ~clk;

   serdes10_datapath i_serdes10_datapath (
      .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_data(tx_data),
      .tx_ovf(tx_ovf), .tx_unf(tx_unf), .ser_out(ser_out), .ser_in(ser_in),
      .loopback(loopback), .comma_en(comma_en), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_comma(rx_comma)
   );

   // {comma_en, expected rx_comma, word}
   localparam logic [11:0] VEC [0:5] = '{
      {1'b1, 1'b1, 10'h17C},
      {1'b1, 1'b0, 10'h2AA},
      {1'b1, 1'b1, 10'h283},
      {1'b1, 1'b0, 10'h155},
      {1'b0, 1'b1, 10'h17C},
      {1'b0, 1'b0, 10'h0F3}
   };

   int         n_chk = 0;
   int         n_err = 0;
   int         edge_n = 0;
   int         unf_n = 0;
   logic [9:0] ser_cap = '0;
   logic [10:0] q_word [$];
   int          q_edge [$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      edge_n++;
      if (rx_valid) begin
         q_word.push_back({rx_comma, rx_data});
         q_edge.push_back(edge_n);
      end
      if (tx_unf) unf_n++;
      if (edge_n >= 11 && edge_n <= 20) ser_cap[edge_n-11] = ser_out;
   endtask

   task automatic send_bits(input logic [9:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         ser_in = w[i];
         tick();
      end
   endtask

   task automatic reset_dut();
      rst = 1'b1;
      tx_wr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      edge_n = 0;
      unf_n = 0;
      q_word.delete();
      q_edge.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [9:0] c, d, exp1, exp2;
      int         idx;
      bit         seen;

      // R10: reset state
      repeat (2) @(posedge clk);
      #2;
      chk(ser_out == 1'b0, "R10 ser_out", ser_out, 0);
      chk(rx_valid == 1'b0, "R10 rx_valid", rx_valid, 0);
      chk(rx_comma == 1'b0, "R10 rx_comma", rx_comma, 0);
      chk(tx_ovf == 1'b0, "R10 tx_ovf", tx_ovf, 0);
      chk(tx_unf == 1'b0, "R10 tx_unf", tx_unf, 0);

      // R5 R6 R8: aligned words from the external input
      reset_dut();
      loopback = 1'b0;
      for (int v = 0; v < 6; v++) begin
         comma_en = VEC[v][11];
         q_word.delete();
         send_bits(VEC[v][9:0], 10);
         chk(q_word.size() == 1, "R5 one word per ten bits", q_word.size(), 1);
         if (q_word.size() >= 1) begin
            chk(q_word[0][9:0] == VEC[v][9:0], "R5 rx_data", q_word[0][9:0], VEC[v][9:0]);
            chk(q_word[0][10] == VEC[v][10], "R6 rx_comma", q_word[0][10], VEC[v][10]);
         end
      end

      // R7: comma three bits off the boundary, realignment enabled
      c = 10'h17C;
      d = 10'h2AA;
      comma_en = 1'b1;
      q_word.delete();
      send_bits(10'b101, 3);
      send_bits(c, 10);
      send_bits(d, 10);
      chk(q_word.size() == 3, "R7 word count", q_word.size(), 3);
      if (q_word.size() == 3) begin
         chk(q_word[1] == {1'b1, c}, "R7 comma word", q_word[1], {1'b1, c});
         chk(q_word[2] == {1'b0, d}, "R7 next word", q_word[2], {1'b0, d});
      end

      // R8: same pattern, realignment disabled, boundary held
      comma_en = 1'b0;
      q_word.delete();
      send_bits(10'b101, 3);
      send_bits(c, 10);
      send_bits(d, 10);
      exp1 = {c[6:0], 3'b101};
      exp2 = {d[6:0], c[9:7]};
      chk(q_word.size() == 2, "R8 word count", q_word.size(), 2);
      if (q_word.size() == 2) begin
         chk(q_word[0] == {1'b0, exp1}, "R8 first held word", q_word[0], {1'b0, exp1});
         chk(q_word[1] == {1'b0, exp2}, "R8 second held word", q_word[1], {1'b0, exp2});
      end

      // R1 R2 R3 R4 R9: transmit through the wrap path
      reset_dut();
      loopback = 1'b1;
      comma_en = 1'b1;
      ser_in = 1'b1;
      tx_wr = 1'b1;
      tx_data = 10'h17C;
      tick();
      chk(tx_unf == 1'b1, "R4 underflow at first load", tx_unf, 1);
      tx_data = 10'h2AA;
      tick();
      chk(tx_unf == 1'b0, "R4 single pulse", tx_unf, 0);
      tx_data = 10'h155;
      tick();
      tx_data = 10'h0F3;
      tick();
      chk(tx_ovf == 1'b0, "R3 fourth write accepted", tx_ovf, 0);
      tx_data = 10'h3C3;
      tick();
      chk(tx_ovf == 1'b1, "R3 fifth write dropped", tx_ovf, 1);
      tx_wr = 1'b0;
      repeat (57) tick();

      chk(ser_cap == 10'h17C, "R2 serial bit order", ser_cap, 10'h17C);
      chk(unf_n == 3, "R4 underflow count", unf_n, 3);
      chk(q_word.size() == 7, "R9 wrapped word count", q_word.size(), 7);
      idx = -1;
      for (int k = 0; k < q_word.size(); k++)
         if (idx < 0 && q_word[k][10]) idx = k;
      chk(idx == 2, "R9 comma via wrap", idx, 2);
      if (idx == 2 && q_word.size() == 7) begin
         chk(q_edge[2] == 21, "R1 first character edge", q_edge[2], 21);
         chk(q_word[3] == {1'b0, 10'h2AA} && q_edge[3] == 31, "R1 second character", q_word[3], 10'h2AA);
         chk(q_word[4] == {1'b0, 10'h155} && q_edge[4] == 41, "R1 third character", q_word[4], 10'h155);
         chk(q_word[5] == {1'b0, 10'h0F3} && q_edge[5] == 51, "R3 fourth character", q_word[5], 10'h0F3);
         chk(q_word[6] == {1'b0, 10'h0F3} && q_edge[6] == 61, "R4 repeated character", q_word[6], 10'h0F3);
      end
      seen = 1'b0;
      for (int k = 0; k < q_word.size(); k++)
         if (q_word[k][9:0] == 10'h3C3) seen = 1'b1;
      chk(!seen, "R3 dropped character absent", seen, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule